// File: doc/BRIEF.md
# UART Interrupt Priority and Identification Unit

This block merges the interrupt requests of a byte-oriented UART into a single interrupt line and an 8-bit identification value. Software reads that value to learn which source to service first. The inputs are:

- the four interrupt enable bits;
- the line status flags;
- the receive character-timeout flag;
- the receive FIFO fill level and its trigger threshold;
- the transmit-holding-empty status;
- the modem status change bits.

The unit ranks the qualified requests with a fixed five-level priority and encodes the winner.

The block owns one piece of state: the transmit-empty pending flag. Strobes from the register decoder control this flag: identification read, enable write, holding-register write and transmit FIFO reset. The unit does not contain the serializers, the FIFOs or the bus decoder. The surrounding UART drives these inputs from its own registers and samples the registered outputs.

Top module: `uart_irq_arbiter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the identification value becomes 0x01, `irq_o` goes low and the transmit-empty pending flag is cleared, whatever the other inputs are.
- R2: Bit 0 of `iid_o` is 1 when no source is pending. Bits 3:0 carry the winning source code: modem change 0x0, transmit empty 0x2, receive data 0x4, line status 0x6, character timeout 0xC. Bits 5:4 are always 0.
- R3: When several sources are pending, the winner is, from highest to lowest: line status, character timeout, receive data, transmit empty, modem change.
- R4: A line status request needs enable bit 2 together with at least one of `lsr_flags` bits 4:1 (break, framing, parity, overrun). Data-ready (`lsr_flags` bit 0) alone never raises it.
- R5: The character-timeout request is qualified by enable bit 0, the same bit as receive data. With bit 0 clear, a set `char_tmo` has no effect.
- R6: The receive data request needs enable bit 0 and data-ready. With `fifo_on` high it also needs `rx_count >= rx_trig`. With `fifo_on` low, data-ready is enough.
- R7: `iid_o` bits 7:6 read 11 while `fifo_on` is high and 00 while it is low.
- R8: `irq_o` is high exactly when `iid_o` bit 0 is 0.
- R9: An `iir_rd` strobe clears the transmit-empty pending flag only when `iid_o` shows code 0x2 at that edge. With any other code shown, the flag is left unchanged.
- R10: An `ier_wr` whose `ier_wdata` bit 1 differs from the current `ien` bit 1 sets the pending flag if the new bit is 1 and `thr_empty` is high. Otherwise it clears the flag. An `ier_wr` that leaves bit 1 unchanged does not touch the flag. The modem change request uses enable bit 3 and any `msr_delta` bit. The transmit-empty request uses enable bit 1 and the pending flag.
- R11: `thr_wr` clears the pending flag and `txf_rst` sets it. When strobes coincide, the order of precedence is `txf_rst`, then `thr_wr`, then `ier_wr`, then `iir_rd`.
- R12: `iid_o` and `irq_o` are registered. They reflect the inputs present at the previous clock edge. An `iir_rd` sees the value shown before its own clear takes effect, and the cleared code appears one edge after the flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ien | input | 4 | Interrupt enables: bit0 receive data/timeout, bit1 transmit empty, bit2 line status, bit3 modem change |
| lsr_flags | input | 5 | bit0 data ready, bit1 overrun, bit2 parity, bit3 framing, bit4 break |
| char_tmo | input | 1 | Receive character-timeout flag |
| fifo_on | input | 1 | FIFO mode enabled |
| rx_count | input | CNT_W | Receive FIFO fill level |
| rx_trig | input | CNT_W | Receive FIFO trigger threshold |
| thr_empty | input | 1 | Transmit holding register/FIFO empty |
| msr_delta | input | 4 | Modem status change bits |
| iir_rd | input | 1 | Identification register read strobe |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 4 | Value being written to the enable register |
| thr_wr | input | 1 | Transmit holding register write strobe |
| txf_rst | input | 1 | Transmit FIFO reset strobe |
| irq_o | output | 1 | Interrupt request |
| iid_o | output | 8 | Identification value |

## Verification
The bench builds the unit with the default FIFO depth of 16, which gives a 5-bit fill count. This puts the usual trigger thresholds 1, 4, 8 and 14 within reach, as well as a completely full FIFO (count 16). The threshold comparison is therefore exercised one below, at and above the trigger. The pending-flag sequences cover strobe collisions and enable writes that do and do not toggle bit 1. These sequences are driven with the enable register modelled in the bench.

// File: rtl/uirq_pkg.sv
// Shared definitions for the UART interrupt arbiter.
// Assumes five sources ranked by index, index 0 being the highest priority.
package uirq_pkg;

    localparam int NSRC = 5;

    // Source indices in priority order (0 wins)
    localparam int SRC_LINE  = 0;
    localparam int SRC_TMO   = 1;
    localparam int SRC_RXD   = 2;
    localparam int SRC_THRE  = 3;
    localparam int SRC_MODEM = 4;

    // Enable bit positions
    localparam int EN_RXD   = 0;
    localparam int EN_THRE  = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

    typedef enum logic [3:0] {
        ID_MODEM = 4'h0,
        ID_NONE  = 4'h1,
        ID_THRE  = 4'h2,
        ID_RXD   = 4'h4,
        ID_LINE  = 4'h6,
        ID_TMO   = 4'hC
    } irq_id_e;

    // Maps a source index to its identification code
    function automatic irq_id_e src_code(input int idx);
        case (idx)
            SRC_LINE: return ID_LINE;
            SRC_TMO:  return ID_TMO;
            SRC_RXD:  return ID_RXD;
            SRC_THRE: return ID_THRE;
            default:  return ID_MODEM;
        endcase
    endfunction

endpackage

// File: rtl/uirq_src_qualify.sv
// Turns raw status and enables into one request bit per source.
// Assumes lsr_flags bit 0 is data ready and bits 4:1 are error/break flags.
module uirq_src_qualify
    import uirq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [3:0]       ien,
    input  logic [4:0]       lsr_flags,
    input  logic             char_tmo,
    input  logic             fifo_on,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             thre_pend,
    input  logic [3:0]       msr_delta,
    output logic [NSRC-1:0]  req
);

    logic line_err;
    logic level_ok;

    // Error summary and receive threshold test
    always_comb begin
        line_err = |lsr_flags[4:1];
        level_ok = !fifo_on || (rx_count >= rx_trig);
    end

    // Per-source qualification with its enable bit
    always_comb begin
        req            = '0;
        req[SRC_LINE]  = ien[EN_LINE] && line_err;
        req[SRC_TMO]   = ien[EN_RXD] && char_tmo;
        req[SRC_RXD]   = ien[EN_RXD] && lsr_flags[0] && level_ok;
        req[SRC_THRE]  = ien[EN_THRE] && thre_pend;
        req[SRC_MODEM] = ien[EN_MODEM] && (|msr_delta);
    end

endmodule

// File: rtl/uirq_thre_flag.sv
// Holds the transmit-empty pending flag and applies its set/clear strobes.
// Assumes en_now is the enable bit currently held by the register file.
module uirq_thre_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic en_now,
    input  logic en_wbit,
    input  logic ier_wr,
    input  logic thr_wr,
    input  logic txf_rst,
    input  logic iir_rd,
    input  logic shown_thre,
    input  logic thr_empty,
    output logic pend
);

    logic en_toggle;

    // Detects an enable write that changes the transmit-empty enable
    always_comb en_toggle = ier_wr && (en_wbit != en_now);

    // Flag update with fixed strobe precedence
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (txf_rst)
            pend <= 1'b1;
        else if (thr_wr)
            pend <= 1'b0;
        else if (en_toggle)
            pend <= en_wbit && thr_empty;
        else if (iir_rd && shown_thre)
            pend <= 1'b0;
    end

endmodule

// File: rtl/uirq_prio_encode.sv
// Picks the highest-priority request and returns its code.
// Assumes index 0 of req has the highest priority.
module uirq_prio_encode
    import uirq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0] req,
    output logic [3:0]   code,
    output logic         hit
);

    // Walk from lowest to highest priority so the highest overwrites
    always_comb begin
        code = ID_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) code = src_code(i);
        end
        hit = |req;
    end

endmodule

// File: rtl/uart_irq_arbiter.sv
// Top of the UART interrupt arbiter: qualifies sources, ranks them and
// registers the identification value and interrupt line.
// Assumes all strobes are single-cycle and synchronous to clk.
module uart_irq_arbiter
    import uirq_pkg::*;
#(
    parameter  int FIFO_DEPTH = 16,
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       ien,
    input  logic [4:0]       lsr_flags,
    input  logic             char_tmo,
    input  logic             fifo_on,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             thr_empty,
    input  logic [3:0]       msr_delta,
    input  logic             iir_rd,
    input  logic             ier_wr,
    input  logic [3:0]       ier_wdata,
    input  logic             thr_wr,
    input  logic             txf_rst,
    output logic             irq_o,
    output logic [7:0]       iid_o
);

    logic [NSRC-1:0] req;
    logic [3:0]      code;
    logic            hit;
    logic            thre_pend;
    logic            shown_thre;
    logic [7:0]      iid_d;

    // The code currently visible to a reader
    always_comb shown_thre = (iid_o[3:0] == ID_THRE);

    uirq_thre_flag u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_now     (ien[EN_THRE]),
        .en_wbit    (ier_wdata[EN_THRE]),
        .ier_wr     (ier_wr),
        .thr_wr     (thr_wr),
        .txf_rst    (txf_rst),
        .iir_rd     (iir_rd),
        .shown_thre (shown_thre),
        .thr_empty  (thr_empty),
        .pend       (thre_pend)
    );

    uirq_src_qualify #(.CNT_W(CNT_W)) u_qual (
        .ien       (ien),
        .lsr_flags (lsr_flags),
        .char_tmo  (char_tmo),
        .fifo_on   (fifo_on),
        .rx_count  (rx_count),
        .rx_trig   (rx_trig),
        .thre_pend (thre_pend),
        .msr_delta (msr_delta),
        .req       (req)
    );

    uirq_prio_encode #(.N(NSRC)) u_enc (
        .req  (req),
        .code (code),
        .hit  (hit)
    );

    // Assemble the identification byte
    always_comb iid_d = {{2{fifo_on}}, 2'b00, code};

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iid_o <= {4'h0, ID_NONE};
            irq_o <= 1'b0;
        end else begin
            iid_o <= iid_d;
            irq_o <= hit;
        end
    end

endmodule

// File: rtl/uart_irq_arbiter_chk.sv
// Property checker for the UART interrupt arbiter, bound to the top module.
module uart_irq_arbiter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] ien,
    input logic [4:0] lsr_flags,
    input logic       char_tmo,
    input logic       fifo_on,
    input logic       thr_empty,
    input logic       iir_rd,
    input logic       ier_wr,
    input logic       ier_wbit,
    input logic       thr_wr,
    input logic       txf_rst,
    input logic       pend,
    input logic       irq_o,
    input logic [7:0] iid_o
);

    // R1: reset clears the outputs and the flag
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (iid_o == 8'h01 && !irq_o && !pend));

    // R4: an enabled line error wins
    assert_line_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ien[2] && |lsr_flags[4:1]) |=> iid_o[3:0] == 4'h6);

    // R3: timeout wins when there is no line request
    assert_tmo_rank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ien[0] && char_tmo && !(ien[2] && |lsr_flags[4:1])) |=> iid_o[3:0] == 4'hC);

    // R5: receive enable off hides both timeout and data codes
    assert_rx_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ien[0] |=> iid_o[2:0] != 3'b100);

    // R7: FIFO mode bits follow fifo_on
    assert_fifo_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_on |=> iid_o[7:6] == 2'b11);
    assert_nofifo_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_on |=> iid_o[7:6] == 2'b00);

    // R8: the line and the identification agree
    assert_irq_agree_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == !iid_o[0]);

    // R9: reading the transmit-empty code clears the flag
    assert_read_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && iid_o[3:0] == 4'h2 && !txf_rst && !thr_wr && !ier_wr) |=> !pend);

    // R10: a toggling enable write rearms from thr_empty
    assert_ier_rearm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_wr && !txf_rst && !thr_wr && (ier_wbit != ien[1]))
            |=> pend == $past(ier_wbit && thr_empty));

    // R11: strobe precedence for the flag
    assert_txf_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
        txf_rst |=> pend);
    assert_thr_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr && !txf_rst) |=> !pend);

endmodule

bind uart_irq_arbiter uart_irq_arbiter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ien       (ien),
    .lsr_flags (lsr_flags),
    .char_tmo  (char_tmo),
    .fifo_on   (fifo_on),
    .thr_empty (thr_empty),
    .iir_rd    (iir_rd),
    .ier_wr    (ier_wr),
    .ier_wbit  (ier_wdata[1]),
    .thr_wr    (thr_wr),
    .txf_rst   (txf_rst),
    .pend      (thre_pend),
    .irq_o     (irq_o),
    .iid_o     (iid_o)
);

// File: tb/uart_irq_arbiter_bench.sv
// Self-checking bench: a vector table for the combinational ranking, then
// directed sequences for reset, latency and the transmit-empty flag.
module uart_irq_arbiter_bench;

    localparam int CW = 5;

    typedef struct packed {
        logic [3:0]    ien;
        logic [4:0]    lsr;
        logic          tmo;
        logic          fifo;
        logic [CW-1:0] cnt;
        logic [CW-1:0] trig;
        logic [3:0]    dlt;
        logic [7:0]    exp;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{4'h0, 5'b00000, 1'b0, 1'b0, 5'd0,  5'd0,  4'h0, 8'h01, 4'd2},  // R2 idle
        '{4'hF, 5'b00010, 1'b0, 1'b0, 5'd0,  5'd0,  4'h0, 8'h06, 4'd4},  // R4 overrun
        '{4'hB, 5'b00010, 1'b0, 1'b0, 5'd0,  5'd0,  4'h1, 8'h00, 4'd4},  // R4 masked, modem
        '{4'hF, 5'b00001, 1'b1, 1'b0, 5'd0,  5'd0,  4'h0, 8'h0C, 4'd3},  // R3 tmo over data
        '{4'hE, 5'b00001, 1'b1, 1'b0, 5'd0,  5'd0,  4'h1, 8'h00, 4'd5},  // R5 tmo masked
        '{4'hF, 5'b00001, 1'b0, 1'b1, 5'd3,  5'd4,  4'h0, 8'hC1, 4'd6},  // R6 below trig
        '{4'hF, 5'b00001, 1'b0, 1'b1, 5'd4,  5'd4,  4'h0, 8'hC4, 4'd6},  // R6 at trig
        '{4'hF, 5'b00001, 1'b0, 1'b0, 5'd0,  5'd14, 4'h0, 8'h04, 4'd6},  // R6 no fifo
        '{4'hF, 5'b00000, 1'b0, 1'b1, 5'd14, 5'd14, 4'h0, 8'hC1, 4'd6},  // R6 needs ready
        '{4'hF, 5'b10001, 1'b1, 1'b0, 5'd0,  5'd0,  4'hF, 8'h06, 4'd3},  // R3 break top
        '{4'hF, 5'b00001, 1'b1, 1'b1, 5'd16, 5'd14, 4'h0, 8'hCC, 4'd3},  // R3 full fifo
        '{4'h8, 5'b00000, 1'b0, 1'b1, 5'd0,  5'd0,  4'h4, 8'hC0, 4'd7},  // R7 modem in fifo
        '{4'h4, 5'b00001, 1'b0, 1'b0, 5'd0,  5'd0,  4'h0, 8'h01, 4'd4},  // R4 ready only
        '{4'h4, 5'b01000, 1'b0, 1'b0, 5'd0,  5'd0,  4'h0, 8'h06, 4'd4},  // R4 framing
        '{4'h4, 5'b00100, 1'b0, 1'b1, 5'd0,  5'd0,  4'h0, 8'hC6, 4'd4}   // R4 parity
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    ien = '0;
    logic [4:0]    lsr_flags = '0;
    logic          char_tmo = 1'b0;
    logic          fifo_on = 1'b0;
    logic [CW-1:0] rx_count = '0;
    logic [CW-1:0] rx_trig = '0;
    logic          thr_empty = 1'b0;
    logic [3:0]    msr_delta = '0;
    logic          iir_rd = 1'b0;
    logic          ier_wr = 1'b0;
    logic [3:0]    ier_wdata = '0;
    logic          thr_wr = 1'b0;
    logic          txf_rst = 1'b0;
    logic          irq_o;
    logic [7:0]    iid_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    uart_irq_arbiter u_uart_irq_arbiter (
        .clk(clk), .rst_n(rst_n), .ien(ien), .lsr_flags(lsr_flags),
        .char_tmo(char_tmo), .fifo_on(fifo_on), .rx_count(rx_count),
        .rx_trig(rx_trig), .thr_empty(thr_empty), .msr_delta(msr_delta),
        .iir_rd(iir_rd), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
        .thr_wr(thr_wr), .txf_rst(txf_rst), .irq_o(irq_o), .iid_o(iid_o)
    );

    task automatic check_iid(input string rq, input logic [7:0] exp);
        n_chk++;
        if (iid_o !== exp || irq_o !== !exp[0]) begin
            n_bad++;
            $display("FAIL %s: iid=%02h irq=%b expected iid=%02h irq=%b",
                     rq, iid_o, irq_o, exp, !exp[0]);
        end
    endtask

    task automatic finish_run;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Quiet the status inputs so only the flag and modem sources matter
    task automatic quiet(input logic [3:0] en);
        ien = en; lsr_flags = '0; char_tmo = 0; fifo_on = 0;
        rx_count = '0; rx_trig = '0; msr_delta = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        // R1: reset dominates active inputs
        @(negedge clk);
        ien = 4'hF; lsr_flags = 5'b00010; txf_rst = 1;
        @(negedge clk); @(negedge clk);
        check_iid("R1", 8'h01);
        txf_rst = 0; quiet(4'h0);
        rst_n = 1;
        @(negedge clk); @(negedge clk);
        check_iid("R1", 8'h01);

        // Table walk: one edge from inputs to outputs
        for (int i = 0; i < NV; i++) begin
            ien = VECS[i].ien; lsr_flags = VECS[i].lsr; char_tmo = VECS[i].tmo;
            fifo_on = VECS[i].fifo; rx_count = VECS[i].cnt;
            rx_trig = VECS[i].trig; msr_delta = VECS[i].dlt;
            @(negedge clk);
            check_iid($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].exp);
        end

        // R12: output holds until the next edge
        quiet(4'h4);
        @(negedge clk);
        lsr_flags = 5'b00010;
        #1 check_iid("R12 before edge", 8'h01);
        @(negedge clk);
        check_iid("R12 after edge", 8'h06);

        // R10: enable write toggling bit 1 on with holding empty arms the flag
        quiet(4'h0); thr_empty = 1;
        ier_wr = 1; ier_wdata = 4'h2;
        @(negedge clk);
        ier_wr = 0; ien = 4'h2;
        @(negedge clk);
        check_iid("R10 arm", 8'h02);

        // R9 and R12: a read sees 0x02, then the code drops
        iir_rd = 1;
        @(negedge clk);
        iir_rd = 0;
        check_iid("R12 read sees old", 8'h02);
        @(negedge clk);
        check_iid("R9 read clears", 8'h01);

        // R10: write without changing bit 1 leaves the flag clear
        ier_wr = 1; ier_wdata = 4'h2;
        @(negedge clk); ier_wr = 0;
        @(negedge clk);
        check_iid("R10 no toggle", 8'h01);

        // R10: toggle off then on with holding busy keeps it clear
        thr_empty = 0;
        ier_wr = 1; ier_wdata = 4'h0;
        @(negedge clk); ien = 4'h0; ier_wdata = 4'h2;
        @(negedge clk); ier_wr = 0; ien = 4'h2;
        @(negedge clk);
        check_iid("R10 busy", 8'h01);

        // R11: FIFO reset sets, holding write clears
        txf_rst = 1;
        @(negedge clk); txf_rst = 0;
        @(negedge clk);
        check_iid("R11 txf_rst sets", 8'h02);
        thr_wr = 1;
        @(negedge clk); thr_wr = 0;
        @(negedge clk);
        check_iid("R11 thr_wr clears", 8'h01);

        // R11: both strobes together, reset wins
        txf_rst = 1; thr_wr = 1;
        @(negedge clk); txf_rst = 0; thr_wr = 0;
        @(negedge clk);
        check_iid("R11 collision", 8'h02);

        // R11: holding write beats a toggling enable write
        ier_wr = 1; ier_wdata = 4'h0; thr_wr = 1; thr_empty = 1;
        @(negedge clk); ier_wr = 0; thr_wr = 0; ien = 4'h0;
        ier_wr = 1; ier_wdata = 4'h2;
        @(negedge clk); ier_wr = 0; ien = 4'h2;
        @(negedge clk);
        check_iid("R11 order then R10 rearm", 8'h02);

        // R9: read while a higher code is shown keeps the flag
        ien = 4'h3; lsr_flags = 5'b00001;
        @(negedge clk);
        check_iid("R3 data over thre", 8'h04);
        iir_rd = 1;
        @(negedge clk); iir_rd = 0; lsr_flags = 5'b00000;
        @(negedge clk);
        check_iid("R9 other code keeps flag", 8'h02);

        // R3: transmit empty outranks modem change
        ien = 4'hA; msr_delta = 4'h2;
        @(negedge clk);
        check_iid("R3 thre over modem", 8'h02);

        finish_run();
    end

endmodule